// File: doc/BRIEF.md
# Per-Pixel Threshold Event Classifier

The block takes one frame of raw pixel samples in raster order and turns it into a stream of tagged hits. For every pixel it removes that pixel's dark level and compares the result with two thresholds that belong to that pixel alone. The higher threshold marks a primary photon event. The lower one marks a charge-sharing constituent, but only when the pixel touches a primary in its 3x3 neighbourhood. A primary with no such neighbour is reported as a single. A primary that has one is reported as the primary of a composite pattern.

The per-pixel dark level and both thresholds are held in internal tables. They are filled through a plain write port before a frame is streamed, and the thresholds are stored already scaled so the datapath only compares. Two line buffers hold the previous rows, and a three-column window slides along the row. A pixel of row r is decided while row r+1 streams in. After the last pixel of a frame the block flushes the final row on its own.

Both the input and the output are valid/ready streams. A transfer takes place on a rising clock edge when valid and ready are both high. While `out_valid` is high and `out_ready` is low, every output field holds its value and `in_ready` stays low, so back-pressure stalls the whole pipeline and no hit is lost. `in_ready` also drops for one cycle after the last pixel of each row, and for a whole flush row after the last pixel of a frame.

Top module: `evc_event_classifier`

## Requirements
- R1: The reported amplitude is the raw sample minus that pixel's dark level, as a signed value one bit wider than the sample.
- R2: A pixel is a primary only when its amplitude is strictly greater than its own primary threshold. A value equal to the threshold is not a primary.
- R3: A pixel that is not a primary is reported with class code 2'b11 (constituent) when its amplitude is strictly greater than its own neighbour threshold and at least one of its 8 neighbours is a primary.
- R4: A primary is reported with class code 2'b01 (single) when none of its 8 neighbours exceeds that neighbour's own neighbour threshold. Otherwise it is reported with code 2'b10 (composite primary).
- R5: A pixel that is neither a primary nor a constituent produces no output. This includes a pixel above its neighbour threshold that has no primary neighbour. Code 2'b00 is never emitted.
- R6: Neighbours that fall outside the frame count as below both thresholds. The last pixel of one row and the first pixel of the next row are not neighbours. Rows of one frame are not neighbours of rows of another frame.
- R7: Each pixel's dark level, primary threshold and neighbour threshold are written at table index row*COLS+col. Two pixels with the same amplitude can therefore be classified differently.
- R8: Hits leave in raster order and carry the row and column of their pixel. No hit of a row is emitted before the first pixel of the next row has been accepted, except for the last row, which is flushed after the frame ends.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and every output field stay stable and `in_ready` is low.
- R10: After reset `in_ready` is high and `out_valid` is low. `in_ready` is low in the cycle that follows acceptance of the last pixel of any row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | $clog2(ROWS*COLS) | Pixel index row*COLS+col for the table write |
| tbl_offset | input | DATA_W | Dark level of the pixel |
| tbl_thr_primary | input | DATA_W | Primary threshold of the pixel |
| tbl_thr_neigh | input | DATA_W | Neighbour threshold of the pixel |
| in_valid | input | 1 | Raw sample valid |
| in_ready | output | 1 | Block accepts a raw sample |
| in_pixel | input | DATA_W | Raw sample, unsigned |
| out_valid | output | 1 | Hit valid |
| out_ready | input | 1 | Downstream accepts the hit |
| out_row | output | $clog2(ROWS) | Row of the hit |
| out_col | output | $clog2(COLS) | Column of the hit |
| out_amp | output | DATA_W+1 | Dark-corrected amplitude, signed |
| out_class | output | 2 | 01 single, 10 composite primary, 11 constituent |

## Verification
The pipeline steps only when the output register can take a result. Two things can therefore meet in one cycle: accepting a new raw sample and holding a stalled hit. The same is true of the row-end bubble and a pending hit. The bench provokes both by throttling `out_ready` at random while it also inserts gaps in `in_valid`, in frames dense with primaries and constituents. A scoreboard judges the result. Every popped hit must match the next expected position, amplitude and class, and a stalled hit must reappear unchanged in the following cycle. The bench also checks that `in_ready` is low in the cycle after each row's last sample.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [1:0] {
    HIT_NONE        = 2'b00,
    HIT_SINGLE      = 2'b01,
    HIT_COMPOSITE   = 2'b10,
    HIT_CONSTITUENT = 2'b11
  } hit_class_e;
endpackage

// File: rtl/evc_tables.sv
// Per-pixel dark level and pre-scaled thresholds, written one pixel at a time.
module evc_tables #(
  parameter int unsigned NPIX = 1024,
  parameter int unsigned DW   = 14,
  parameter int unsigned AW   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_off,
  input  logic [DW-1:0] wr_hi,
  input  logic [DW-1:0] wr_lo,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_off,
  output logic [DW-1:0] rd_hi,
  output logic [DW-1:0] rd_lo
);
  logic [DW-1:0] off_mem [NPIX];
  logic [DW-1:0] hi_mem  [NPIX];
  logic [DW-1:0] lo_mem  [NPIX];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      off_mem[wr_addr] <= wr_off;
      hi_mem[wr_addr]  <= wr_hi;
      lo_mem[wr_addr]  <= wr_lo;
    end
  end

  assign rd_off = off_mem[rd_addr];
  assign rd_hi  = hi_mem[rd_addr];
  assign rd_lo  = lo_mem[rd_addr];

  AST_TBL_ADDR: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> ({1'b0, wr_addr} < (AW+1)'(NPIX))); // R7
endmodule

// File: rtl/evc_linebuf.sv
// Two row stores used ping-pong: one holds the centre row, the other the row above
// and is overwritten column by column with the incoming row.
module evc_linebuf #(
  parameter int unsigned COLS = 64,
  parameter int unsigned CW   = 17,
  parameter int unsigned CIW  = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CIW-1:0] col,
  input  logic           wr_en,
  input  logic [CW-1:0]  wr_cell,
  input  logic           flip,
  output logic [CW-1:0]  cen_cell,
  output logic [1:0]     abv_flags
);
  localparam int unsigned IW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam logic [CIW-1:0] COL_END = CIW'(COLS);

  logic [CW-1:0] mem [2][COLS];
  logic          sel;
  logic          in_range;
  logic [IW-1:0] idx;
  logic [CW-1:0] abv_cell;

  assign in_range = (col != COL_END);
  assign idx      = col[IW-1:0];

  always_ff @(posedge clk) begin
    if (wr_en) mem[~sel][idx] <= wr_cell;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel <= 1'b0;
    else if (flip) sel <= ~sel;
  end

  assign cen_cell  = in_range ? mem[sel][idx]  : '0;
  assign abv_cell  = in_range ? mem[~sel][idx] : '0;
  assign abv_flags = abv_cell[CW-1:CW-2];

  AST_FLIP_ROW_END: assert property (@(posedge clk) disable iff (!rst_n) flip |-> !in_range); // R10
  AST_WR_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> in_range); // R8
endmodule

// File: rtl/evc_window.sv
// Three-column flag window; the middle column's centre row is the pixel decided.
// Flag layout per column: [5:4] above {p,n}, [3:2] centre {p,n}, [1:0] below {p,n}.
module evc_window
  import evc_pkg::*;
#(
  parameter int unsigned AMP_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic [5:0]       flags_new,
  input  logic [AMP_W-1:0] amp_new,
  output hit_class_e       cls,
  output logic [AMP_W-1:0] cen_amp
);
  logic [5:0]       f1, f2;
  logic [AMP_W-1:0] a1;
  logic [2:0]       p_l, n_l, p_m, n_m, p_r, n_r;
  logic             nb_n, nb_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f1 <= '0;
      f2 <= '0;
      a1 <= '0;
    end else if (shift) begin
      f2 <= f1;
      f1 <= flags_new;
      a1 <= amp_new;
    end
  end

  for (genvar j = 0; j < 3; j++) begin : g_flag
    assign p_l[j] = f2[2*j+1];
    assign n_l[j] = f2[2*j];
    assign p_m[j] = f1[2*j+1];
    assign n_m[j] = f1[2*j];
    assign p_r[j] = flags_new[2*j+1];
    assign n_r[j] = flags_new[2*j];
  end

  assign nb_n = (|n_l) | (|n_r) | n_m[2] | n_m[0];
  assign nb_p = (|p_l) | (|p_r) | p_m[2] | p_m[0];

  always_comb begin
    if (p_m[1])               cls = nb_n ? HIT_COMPOSITE : HIT_SINGLE;
    else if (n_m[1] && nb_p)  cls = HIT_CONSTITUENT;
    else                      cls = HIT_NONE;
  end

  assign cen_amp = a1;
endmodule

// File: rtl/evc_event_classifier.sv
module evc_event_classifier
  import evc_pkg::*;
#(
  parameter int unsigned ROWS   = 16,
  parameter int unsigned COLS   = 64,
  parameter int unsigned DATA_W = 14,
  localparam int unsigned AW    = $clog2(ROWS*COLS),
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned COL_W = $clog2(COLS),
  localparam int unsigned AMP_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [DATA_W-1:0] tbl_offset,
  input  logic [DATA_W-1:0] tbl_thr_primary,
  input  logic [DATA_W-1:0] tbl_thr_neigh,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_pixel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ROW_W-1:0]  out_row,
  output logic [COL_W-1:0]  out_col,
  output logic [AMP_W-1:0]  out_amp,
  output logic [1:0]        out_class
);
  localparam int unsigned NPIX = ROWS * COLS;
  localparam int unsigned RW   = $clog2(ROWS + 1);
  localparam int unsigned CIW  = $clog2(COLS + 1);
  localparam int unsigned CW   = AMP_W + 2;
  localparam logic [RW-1:0]  ROW_END = RW'(ROWS);
  localparam logic [CIW-1:0] COL_END = CIW'(COLS);

  // Step counters: rin = incoming row (ROWS means flush row), kc = column step (COLS means bubble)
  logic [RW-1:0]  rin;
  logic [CIW-1:0] kc;
  logic [AW-1:0]  pix;
  logic           need_in, out_can, adv, dec_ok;

  logic [DATA_W-1:0]       rd_off, rd_hi, rd_lo;
  logic signed [AMP_W-1:0] amp_in;
  logic                    is_pri, is_nb;
  logic [CW-1:0]           cell_in, cen_cell, cen_g;
  logic [1:0]              abv_flags, abv_g;
  hit_class_e              cls;
  logic [AMP_W-1:0]        cen_amp;

  assign need_in  = (rin != ROW_END) && (kc != COL_END);
  assign out_can  = !out_valid || out_ready;
  assign adv      = out_can && (need_in ? in_valid : 1'b1);
  assign in_ready = need_in && out_can;
  assign dec_ok   = (rin != '0) && (kc != '0);

  evc_tables #(.NPIX(NPIX), .DW(DATA_W), .AW(AW)) u_tables (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_addr(tbl_addr),
    .wr_off(tbl_offset), .wr_hi(tbl_thr_primary), .wr_lo(tbl_thr_neigh),
    .rd_addr(pix), .rd_off(rd_off), .rd_hi(rd_hi), .rd_lo(rd_lo)
  );

  assign amp_in  = $signed({1'b0, in_pixel}) - $signed({1'b0, rd_off});
  assign is_pri  = amp_in > $signed({1'b0, rd_hi});
  assign is_nb   = amp_in > $signed({1'b0, rd_lo});
  assign cell_in = need_in ? {is_pri, is_nb, amp_in} : '0;

  evc_linebuf #(.COLS(COLS), .CW(CW), .CIW(CIW)) u_linebuf (
    .clk(clk), .rst_n(rst_n), .col(kc),
    .wr_en(adv && need_in), .wr_cell(cell_in),
    .flip(adv && (kc == COL_END)),
    .cen_cell(cen_cell), .abv_flags(abv_flags)
  );

  // Rows outside the frame read as empty
  assign cen_g = (rin != '0) ? cen_cell : '0;
  assign abv_g = (rin >= RW'(2)) ? abv_flags : 2'b00;

  evc_window #(.AMP_W(AMP_W)) u_window (
    .clk(clk), .rst_n(rst_n), .shift(adv),
    .flags_new({abv_g, cen_g[CW-1:CW-2], cell_in[CW-1:CW-2]}),
    .amp_new(cen_g[AMP_W-1:0]),
    .cls(cls), .cen_amp(cen_amp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rin <= '0;
      kc  <= '0;
      pix <= '0;
    end else if (adv) begin
      if (kc == COL_END) begin
        kc <= '0;
        if (rin == ROW_END) begin
          rin <= '0;
          pix <= '0;
        end else begin
          rin <= rin + 1'b1;
        end
      end else begin
        kc <= kc + 1'b1;
        if (need_in) pix <= pix + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_row   <= '0;
      out_col   <= '0;
      out_amp   <= '0;
      out_class <= 2'b00;
    end else if (adv) begin
      out_valid <= dec_ok && (cls != HIT_NONE);
      out_row   <= ROW_W'(rin - 1'b1);
      out_col   <= COL_W'(kc - 1'b1);
      out_amp   <= cen_amp;
      out_class <= cls;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_col) && $stable(out_amp) && $stable(out_class))); // R9
  AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |-> !in_ready); // R9
  AST_CLASS_CODE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_class != 2'b00)); // R5
  AST_HIT_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !out_amp[AMP_W-1]); // R2
  AST_ROW_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n) (kc == COL_END) |-> !in_ready); // R10
endmodule

// File: tb/sim_evc_event_classifier.sv
`timescale 1ns/1ps
module sim_evc_event_classifier;
  localparam int R = 6;
  localparam int C = 8;
  localparam int N = R * C;
  localparam int DW = 10;
  localparam int AW = $clog2(N);
  localparam int ROW_W = $clog2(R);
  localparam int COL_W = $clog2(C);
  localparam int AMP_W = DW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [AW-1:0] tbl_addr = '0;
  logic [DW-1:0] tbl_offset = '0, tbl_thr_primary = '0, tbl_thr_neigh = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_pixel = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [ROW_W-1:0] out_row;
  logic [COL_W-1:0] out_col;
  logic [AMP_W-1:0] out_amp;
  logic [1:0] out_class;

  always #2.5 clk = ~clk;

  evc_event_classifier #(.ROWS(R), .COLS(C), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_offset(tbl_offset), .tbl_thr_primary(tbl_thr_primary), .tbl_thr_neigh(tbl_thr_neigh),
    .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row), .out_col(out_col),
    .out_amp(out_amp), .out_class(out_class)
  );

  typedef struct {int row; int col; int amp; int cls;} hit_t;
  hit_t exp_q[$];

  int raw[N], off[N], hi[N], lo[N];
  int checks = 0, fails = 0, rx_cnt = 0, cycles = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_up();
    end
  end

  // monitor: pops and compares each hit transferred at the next rising edge
  bit prev_stall = 0;
  int prev_row, prev_col, prev_amp, prev_cls;
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (prev_stall) begin
        chk(out_valid && int'(out_row) == prev_row && int'(out_col) == prev_col &&
            int'($signed(out_amp)) == prev_amp && int'(out_class) == prev_cls,
            "R9 stalled hit held", int'(out_valid), 1);
      end
      prev_stall = out_valid && !out_ready;
      prev_row = int'(out_row); prev_col = int'(out_col);
      prev_amp = int'($signed(out_amp)); prev_cls = int'(out_class);
      if (out_valid && out_ready) begin
        rx_cnt++;
        if (exp_q.size() == 0) begin
          chk(0, "R8 unexpected hit at row*C+col", int'(out_row) * C + int'(out_col), -1);
        end else begin
          hit_t e;
          e = exp_q.pop_front();
          chk(int'(out_row) == e.row && int'(out_col) == e.col, "R8 hit position row*C+col",
              int'(out_row) * C + int'(out_col), e.row * C + e.col);
          chk(int'($signed(out_amp)) == e.amp, "R1 corrected amplitude", int'($signed(out_amp)), e.amp);
          chk(int'(out_class) == e.cls, (e.cls == 3) ? "R3 constituent class" : "R4 primary class",
              int'(out_class), e.cls);
        end
      end
    end
  end

  task automatic set_base();
    for (int i = 0; i < N; i++) begin
      off[i] = 100 + (i % 7); hi[i] = 50; lo[i] = 25; raw[i] = off[i];
    end
  endtask

  task automatic put(input int r, input int c, input int a);
    raw[r*C+c] = off[r*C+c] + a;
  endtask

  task automatic load_tables();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = AW'(i);
      tbl_offset = DW'(off[i]); tbl_thr_primary = DW'(hi[i]); tbl_thr_neigh = DW'(lo[i]);
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic build_expect();
    bit p[N], n[N];
    for (int i = 0; i < N; i++) begin
      p[i] = (raw[i] - off[i]) > hi[i];
      n[i] = (raw[i] - off[i]) > lo[i];
    end
    for (int r = 0; r < R; r++) begin
      for (int c = 0; c < C; c++) begin
        bit anyp, anyn;
        hit_t h;
        anyp = 0; anyn = 0;
        for (int dr = -1; dr <= 1; dr++) begin
          for (int dc = -1; dc <= 1; dc++) begin
            if ((dr != 0 || dc != 0) && r+dr >= 0 && r+dr < R && c+dc >= 0 && c+dc < C) begin
              anyp |= p[(r+dr)*C + c+dc];
              anyn |= n[(r+dr)*C + c+dc];
            end
          end
        end
        h.row = r; h.col = c; h.amp = raw[r*C+c] - off[r*C+c]; h.cls = 0;
        if (p[r*C+c]) h.cls = anyn ? 2 : 1;
        else if (n[r*C+c] && anyp) h.cls = 3;
        if (h.cls != 0) exp_q.push_back(h);
      end
    end
  endtask

  task automatic run_frame(input int bp, input int gaps, input string tag);
    int idx, tail, exp_n;
    bit bubble_pending;
    idx = 0; tail = 0; bubble_pending = 0;
    load_tables();
    build_expect();
    exp_n = exp_q.size();
    rx_cnt = 0;
    while (tail < 3 * (C + 1) + 40) begin
      @(negedge clk);
      out_ready = (bp == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
      if (idx < N) begin
        in_valid = (gaps == 0) ? 1'b1 : ($urandom_range(0, 3) != 0);
        in_pixel = DW'(raw[idx]);
      end else begin
        in_valid = 1'b0;
        tail++;
      end
      #1;
      if (bubble_pending) begin
        chk(!in_ready, "R10 in_ready low after row end", int'(in_ready), 0);
        bubble_pending = 0;
      end
      if (in_valid && in_ready) begin
        if (idx % C == C - 1) bubble_pending = 1;
        idx++;
      end
    end
    in_valid = 1'b0;
    chk(exp_q.size() == 0 && rx_cnt == exp_n, tag, rx_cnt, exp_n);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!out_valid, "R10 reset out_valid", int'(out_valid), 0);
    chk(in_ready, "R10 reset in_ready", int'(in_ready), 1);

    // R2/R5/R7: equal-to-threshold values, a lone mid-level pixel, own neighbour threshold
    set_base();
    put(2, 3, 60);
    put(4, 6, 50);
    put(0, 0, 25);
    lo[2*C+4] = 40; put(2, 4, 30);
    put(5, 1, -30);
    run_frame(0, 0, "R2/R5 frame A hit count");

    // R3/R4/R7: composite pattern, per-pixel thresholds, adjacent primaries
    set_base();
    put(3, 3, 80); put(2, 2, 26); put(4, 4, 25);
    hi[1*C+6] = 200; put(1, 6, 100);
    hi[5*C+6] = 20; lo[5*C+6] = 10; put(5, 6, 30);
    put(0, 6, 70); put(0, 7, 90);
    run_frame(0, 1, "R3/R4/R7 frame B hit count");

    // R6: corners, row wrap in raster order, bottom row
    set_base();
    put(0, 0, 70); put(0, 7, 70); put(1, 0, 30);
    put(2, 7, 30); put(3, 0, 70);
    put(5, 7, 70); put(5, 2, 70); put(4, 0, 30);
    run_frame(1, 1, "R6 frame C hit count");

    // R6: top row must not see the previous frame's bottom row
    set_base();
    put(0, 2, 30); put(0, 3, 30);
    run_frame(1, 0, "R6 frame D hit count");

    // R9 and general: random frames under random back-pressure
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < N; i++) begin
        int a;
        off[i] = 100 + $urandom_range(0, 20);
        hi[i] = $urandom_range(30, 70);
        lo[i] = hi[i] / 2;
        a = ($urandom_range(0, 5) == 0) ? $urandom_range(40, 100) : ($urandom_range(0, 45) - 20);
        raw[i] = off[i] + a;
      end
      run_frame(1, 1, "R9 random frame hit count");
    end

    finish_up();
  end
endmodule